// File: doc/BRIEF.md
# DMA channel transfer sequencer

This block is the engine of a single DMA channel. A transfer is organised in four levels. A beat is one read of the source followed by one write of the destination. A burst is a fixed number of beats that run back to back. A block is the set of beats that one descriptor defines. A transaction is a chain of blocks joined by next-descriptor pointers. The channel reads each descriptor as four 32-bit words over the same memory port it uses for data. It walks the beats while stepping the source and destination addresses. When a block ends it follows the link, and it stops when it reaches a null link.

Software arms the channel with a pulse that also loads the address of the first descriptor. After that, a peripheral request line, a software strobe or an event input starts the transaction. Before every burst the channel asks an external arbiter for a grant. Holding back the grant pauses a block between bursts, and no beat is lost or repeated. Block and transaction completion each give a one-cycle pulse. They can also set a sticky interrupt flag if the descriptor enables it.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `chan_en`, `mem_req`, `arb_req`, `blk_irq` and `txn_irq` are low. An `en_set` pulse while idle sets `chan_en` on the next cycle and latches `desc_base` as the first descriptor address. Any of `trig_periph`, `trig_sw` or `trig_evt` starts a transaction only while `chan_en` is high and the channel is idle; a trigger while `chan_en` is low makes no memory request.
- R2: A descriptor is read as four 32-bit word reads (`mem_size` = 2) at pointer, pointer+4, pointer+8 and pointer+12. The words are, in that order: control, source address, destination address, next-descriptor pointer.
- R3: Control word fields: bits [CNT_W-1:0] hold the beat count, where 0 means 2^CNT_W beats. Bits [17:16] hold the beat size: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. `mem_size` never shows 3.
- R4: Each beat is one read at the current source address, then one write to the current destination address. The write carries the read data and uses the beat size code on `mem_size`.
- R5: If control bit 18 (source step) or bit 19 (destination step) is set, that address advances by the beat size in bytes after every beat. If the bit is clear, the address stays fixed for the whole block.
- R6: `arb_req` is raised before each burst and held until `arb_gnt`. A grant allows `burst_len_m1`+1 beats with no further arbitration. The last burst of a block may be shorter.
- R7: While `arb_req` is high, `mem_req` is low. Any delay of the grant pauses the block with no beat lost or repeated.
- R8: At the end of a block, a non-zero next pointer starts the fetch of that descriptor. A zero pointer ends the transaction.
- R9: `blk_done` is a one-cycle pulse for each block. `txn_done` pulses in the same cycle as the last block's `blk_done`, and `chan_en` is low from that cycle on.
- R10: `blk_irq` is set at a block end if control bit 20 of that descriptor is set. `txn_irq` is set at transaction end if control bit 21 of the last descriptor is set. Both stay set until `irq_clr`.
- R11: Once raised, `mem_req` holds `mem_addr` and `mem_we` steady until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Arm the channel and latch the first descriptor address |
| desc_base | input | AW | First descriptor address |
| burst_len_m1 | input | BL_W | Beats per burst minus one |
| trig_periph | input | 1 | Peripheral request trigger |
| trig_sw | input | 1 | Software trigger strobe |
| trig_evt | input | 1 | Event trigger |
| arb_req | output | 1 | Request to the channel arbiter for the next burst |
| arb_gnt | input | 1 | One-cycle grant from the arbiter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq_clr | input | 1 | Clear both interrupt flags |
| chan_en | output | 1 | Channel armed or busy |
| blk_done | output | 1 | Block finished pulse |
| txn_done | output | 1 | Transaction finished pulse |
| blk_irq | output | 1 | Sticky block interrupt flag |
| txn_irq | output | 1 | Sticky transaction interrupt flag |

## Verification
`chan_en` rises one cycle after `en_set`. The first descriptor read request appears one cycle after an accepted trigger, and each access completes on the cycle its acknowledge is seen. `blk_done`, `txn_done`, the flag updates and the drop of `chan_en` all land two edges after the acknowledge of a block's final write. Because arbiter and memory latency are random, the bench does not count fixed cycles. It samples every signal on the falling edge, waits for the `txn_done` pulse, and only then compares memory, grant counts, descriptor reads, done counts and flags. Per-cycle rules, such as request holding, burst length and pulse width, are checked on every falling edge by monitors.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ARB, S_RD, S_WR, S_BEND
  } seq_state_e;

  localparam int CTL_SIZE_LSB = 16;
  localparam int CTL_SRC_STEP = 18;
  localparam int CTL_DST_STEP = 19;
  localparam int CTL_BLK_IRQ  = 20;
  localparam int CTL_TXN_IRQ  = 21;

  // size code 3 is treated as a word access (R3)
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dseq_addr_step.sv
module dseq_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic          step_en,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt
);
  // next beat address: advance by 1, 2 or 4 bytes when stepping (R5)
  always_comb begin
    nxt = cur;
    if (step_en) nxt = cur + (AW'(1) << size);
  end
endmodule

// File: rtl/dseq_down_ctr.sv
module dseq_down_ctr #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

  // a loaded count is never zero and never runs below zero (R3, R6)
  assert_ctr_load_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> load_val != '0);
  assert_ctr_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    dec |-> cnt != '0);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dseq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int BL_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_set,
  input  logic [AW-1:0]   desc_base,
  input  logic [BL_W-1:0] burst_len_m1,
  input  logic            trig_periph,
  input  logic            trig_sw,
  input  logic            trig_evt,
  output logic            arb_req,
  input  logic            arb_gnt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_size,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  input  logic            irq_clr,
  output logic            chan_en,
  output logic            blk_done,
  output logic            txn_done,
  output logic            blk_irq,
  output logic            txn_irq
);
  localparam int BLK_W = CNT_W + 1;
  localparam int BST_W = BL_W + 1;

  seq_state_e state;
  logic          en_q;
  logic [AW-1:0] desc_ptr, src_a, dst_a, nxt_q, addr_q;
  logic [1:0]    fidx, bsize, size_q;
  logic          src_step, dst_step, birq_en, tirq_en;
  logic          req_q, we_q, arbreq_q, bdone_q, tdone_q, birq_q, tirq_q;
  logic [31:0]   wdata_q;
  logic [AW-1:0] src_nx, dst_nx;

  logic trig_any;
  assign trig_any = trig_periph | trig_sw | trig_evt;

  dseq_addr_step #(.AW(AW)) u_src_step (
    .cur(src_a), .step_en(src_step), .size(bsize), .nxt(src_nx));
  dseq_addr_step #(.AW(AW)) u_dst_step (
    .cur(dst_a), .step_en(dst_step), .size(bsize), .nxt(dst_nx));

  // beats left in the block; a zero count field means 2^CNT_W (R3)
  logic             blk_load, beat_end, blk_last, bst_load, bst_last;
  logic [BLK_W-1:0] blk_val;
  logic [BST_W-1:0] bst_val;

  assign blk_load = (state == S_FETCH) && mem_ack && (fidx == 2'd0);
  assign blk_val  = (mem_rdata[CNT_W-1:0] == '0) ? {1'b1, {CNT_W{1'b0}}}
                                                 : {1'b0, mem_rdata[CNT_W-1:0]};
  assign beat_end = (state == S_WR) && mem_ack;
  assign bst_load = (state == S_ARB) && arb_gnt;
  assign bst_val  = {1'b0, burst_len_m1} + BST_W'(1);

  dseq_down_ctr #(.W(BLK_W)) u_blk_ctr (
    .clk(clk), .rst(rst), .load(blk_load), .load_val(blk_val),
    .dec(beat_end), .last(blk_last));
  dseq_down_ctr #(.W(BST_W)) u_bst_ctr (
    .clk(clk), .rst(rst), .load(bst_load), .load_val(bst_val),
    .dec(beat_end), .last(bst_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      en_q     <= 1'b0;
      desc_ptr <= '0;
      src_a    <= '0;
      dst_a    <= '0;
      nxt_q    <= '0;
      addr_q   <= '0;
      fidx     <= 2'd0;
      bsize    <= 2'd0;
      size_q   <= 2'd0;
      src_step <= 1'b0;
      dst_step <= 1'b0;
      birq_en  <= 1'b0;
      tirq_en  <= 1'b0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      arbreq_q <= 1'b0;
      bdone_q  <= 1'b0;
      tdone_q  <= 1'b0;
      birq_q   <= 1'b0;
      tirq_q   <= 1'b0;
      wdata_q  <= '0;
    end else begin
      bdone_q <= 1'b0;
      tdone_q <= 1'b0;
      if (irq_clr) begin
        birq_q <= 1'b0;
        tirq_q <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (en_set) begin
            en_q     <= 1'b1;
            desc_ptr <= desc_base;
          end else if (en_q && trig_any) begin
            state  <= S_FETCH;
            fidx   <= 2'd0;
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            size_q <= 2'd2;
            addr_q <= desc_ptr;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            case (fidx)
              2'd0: begin
                bsize    <= norm_size(mem_rdata[CTL_SIZE_LSB +: 2]);
                src_step <= mem_rdata[CTL_SRC_STEP];
                dst_step <= mem_rdata[CTL_DST_STEP];
                birq_en  <= mem_rdata[CTL_BLK_IRQ];
                tirq_en  <= mem_rdata[CTL_TXN_IRQ];
              end
              2'd1:    src_a <= mem_rdata[AW-1:0];
              2'd2:    dst_a <= mem_rdata[AW-1:0];
              default: nxt_q <= mem_rdata[AW-1:0];
            endcase
            if (fidx == 2'd3) begin
              req_q    <= 1'b0;
              arbreq_q <= 1'b1;
              state    <= S_ARB;
            end else begin
              fidx   <= fidx + 2'd1;
              addr_q <= addr_q + AW'(4);
            end
          end
        end
        S_ARB: begin
          if (arb_gnt) begin
            arbreq_q <= 1'b0;
            state    <= S_RD;
            req_q    <= 1'b1;
            we_q     <= 1'b0;
            addr_q   <= src_a;
            size_q   <= bsize;
          end
        end
        S_RD: begin
          if (mem_ack) begin
            wdata_q <= mem_rdata;
            we_q    <= 1'b1;
            addr_q  <= dst_a;
            state   <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ack) begin
            src_a <= src_nx;
            dst_a <= dst_nx;
            we_q  <= 1'b0;
            if (blk_last) begin
              req_q <= 1'b0;
              state <= S_BEND;
            end else if (bst_last) begin
              req_q    <= 1'b0;
              arbreq_q <= 1'b1;
              state    <= S_ARB;
            end else begin
              addr_q <= src_nx;
              state  <= S_RD;
            end
          end
        end
        S_BEND: begin
          bdone_q <= 1'b1;
          if (birq_en) birq_q <= 1'b1;
          if (nxt_q == '0) begin
            tdone_q <= 1'b1;
            en_q    <= 1'b0;
            if (tirq_en) tirq_q <= 1'b1;
            state   <= S_IDLE;
          end else begin
            desc_ptr <= nxt_q;
            state    <= S_FETCH;
            fidx     <= 2'd0;
            req_q    <= 1'b1;
            we_q     <= 1'b0;
            size_q   <= 2'd2;
            addr_q   <= nxt_q;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign arb_req   = arbreq_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_size  = size_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign chan_en   = en_q;
  assign blk_done  = bdone_q;
  assign txn_done  = tdone_q;
  assign blk_irq   = birq_q;
  assign txn_irq   = tirq_q;

  // beats since the last grant, against the burst length latched at the grant
  logic [BST_W-1:0] chk_beats, chk_bl;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_beats <= '0;
      chk_bl    <= '0;
    end else if (bst_load) begin
      chk_beats <= '0;
      chk_bl    <= bst_val;
    end else if (beat_end) begin
      chk_beats <= chk_beats + BST_W'(1);
    end
  end

  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (rst)
    chk_beats <= chk_bl);
  assert_no_req_in_arb_R7: assert property (@(posedge clk) disable iff (rst)
    arb_req |-> !mem_req);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_size_legal_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_size != 2'd3);
  assert_blk_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done);
  assert_txn_end_R9: assert property (@(posedge clk) disable iff (rst)
    txn_done |-> blk_done && !chan_en);
  assert_idle_trig_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    !chan_en && state == S_IDLE |=> !mem_req);
endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int AW    = 32;
  localparam int CNT_W = 6;
  localparam int BL_W  = 4;
  localparam int MEM_B = 4096;
  localparam int DESC0 = 32'h100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic            en_set;
  logic [AW-1:0]   desc_base;
  logic [BL_W-1:0] burst_len_m1;
  logic            trig_periph, trig_sw, trig_evt;
  logic            arb_req, arb_gnt;
  logic            mem_req, mem_we, mem_ack;
  logic [1:0]      mem_size;
  logic [AW-1:0]   mem_addr;
  logic [31:0]     mem_wdata, mem_rdata;
  logic            irq_clr, chan_en, blk_done, txn_done, blk_irq, txn_irq;

  dma_chan_seq #(.AW(AW), .CNT_W(CNT_W), .BL_W(BL_W)) u_dut (
    .clk(clk), .rst(rst), .en_set(en_set), .desc_base(desc_base),
    .burst_len_m1(burst_len_m1), .trig_periph(trig_periph), .trig_sw(trig_sw),
    .trig_evt(trig_evt), .arb_req(arb_req), .arb_gnt(arb_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq_clr(irq_clr), .chan_en(chan_en),
    .blk_done(blk_done), .txn_done(txn_done), .blk_irq(blk_irq),
    .txn_irq(txn_irq));

  logic [7:0] mem  [MEM_B];
  logic [7:0] refm [MEM_B];

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [11:0] ix(input logic [11:0] a, input int k);
    return a + 12'(k);
  endfunction

  // memory model: acknowledges one cycle after a request is seen
  logic [11:0] ma;
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      ma = mem_addr[11:0];
      if (mem_we) begin
        mem[ma] = mem_wdata[7:0];
        if (mem_size != 2'd0) mem[ix(ma, 1)] = mem_wdata[15:8];
        if (mem_size == 2'd2) begin
          mem[ix(ma, 2)] = mem_wdata[23:16];
          mem[ix(ma, 3)] = mem_wdata[31:24];
        end
      end else begin
        mem_rdata <= {mem[ix(ma, 3)], mem[ix(ma, 2)], mem[ix(ma, 1)], mem[ma]};
      end
      mem_ack <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // arbiter model with a random grant delay
  int unsigned gnt_max = 0;
  int unsigned dly = 0;
  always @(posedge clk) begin
    if (rst) begin
      arb_gnt <= 1'b0;
      dly     <= 0;
    end else if (arb_gnt) begin
      arb_gnt <= 1'b0;
      dly     <= (gnt_max == 0) ? 0 : $urandom_range(gnt_max, 0);
    end else if (arb_req) begin
      if (dly == 0) arb_gnt <= 1'b1;
      else dly <= dly - 1;
    end
  end

  // falling-edge monitors
  int n_req = 0, n_gnt = 0, n_blk = 0, n_txn = 0, n_descrd = 0;
  int v_arb = 0, v_hold = 0, v_data = 0, v_burst = 0, v_pulse = 0, v_txn = 0;
  logic        p_req = 1'b0, p_ack = 1'b0, p_blk = 1'b0;
  logic [31:0] p_addr = '0, last_rd = '0;
  int beats_b = 0, cur_bl = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) n_req++;
      if (arb_req && mem_req) v_arb++;
      if (p_req && !p_ack && mem_req && mem_addr != p_addr) v_hold++;
      if (mem_req && mem_ack && !mem_we) begin
        last_rd = mem_rdata;
        if (mem_addr >= 32'h100 && mem_addr < 32'h400) n_descrd++;
      end
      if (mem_req && mem_ack && mem_we) begin
        if (mem_wdata != last_rd) v_data++;
        beats_b++;
        if (beats_b > cur_bl) v_burst++;
      end
      if (arb_req && arb_gnt) begin
        n_gnt++;
        beats_b = 0;
        cur_bl  = int'(burst_len_m1) + 1;
      end
      if (blk_done) begin
        n_blk++;
        if (p_blk) v_pulse++;
      end
      if (txn_done) begin
        n_txn++;
        if (!blk_done || chan_en) v_txn++;
      end
      p_req  = mem_req;
      p_ack  = mem_ack;
      p_addr = mem_addr;
      p_blk  = blk_done;
    end
  end

  task automatic report_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      report_and_end();
    end
  end

  // descriptor chain set-up
  int nd;
  int d_cnt[4];
  int d_sz[4];
  bit d_si[4], d_di[4], d_bie[4], d_tie[4];

  task automatic put_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[(a + k) & 12'hFFF] = w[8*k +: 8];
  endtask

  function automatic int beats_of(input int c);
    return (c == 0) ? (1 << CNT_W) : c;
  endfunction

  task automatic build_chain();
    for (int a = 32'h800; a < MEM_B; a++) mem[a] = 8'h00;
    for (int d = 0; d < nd; d++) begin
      logic [31:0] ctl;
      ctl = {10'd0, d_tie[d], d_bie[d], d_di[d], d_si[d], 2'(d_sz[d]), 16'(d_cnt[d])};
      put_word(DESC0 + d * 16, ctl);
      put_word(DESC0 + d * 16 + 4, 32'h400 + d * 32'h100);
      put_word(DESC0 + d * 16 + 8, 32'h800 + d * 32'h100);
      put_word(DESC0 + d * 16 + 12, (d < nd - 1) ? DESC0 + (d + 1) * 16 : 0);
    end
    for (int a = 0; a < MEM_B; a++) refm[a] = mem[a];
    for (int d = 0; d < nd; d++) begin
      int nb, by;
      nb = beats_of(d_cnt[d]);
      by = (d_sz[d] >= 2) ? 4 : (1 << d_sz[d]);
      for (int i = 0; i < nb; i++) begin
        int sa, da;
        sa = 32'h400 + d * 32'h100 + (d_si[d] ? i * by : 0);
        da = 32'h800 + d * 32'h100 + (d_di[d] ? i * by : 0);
        for (int b = 0; b < by; b++) refm[(da + b) & 12'hFFF] = refm[(sa + b) & 12'hFFF];
      end
    end
  endtask

  task automatic run_txn(input int trig_sel, input int bl, input string tag);
    int g0, b0, t0, r0, exp_g, bad, wait_c;
    bit exp_bi;
    build_chain();
    @(negedge clk);
    irq_clr = 1'b1;
    burst_len_m1 = BL_W'(bl - 1);
    @(negedge clk);
    irq_clr = 1'b0;
    en_set = 1'b1;
    desc_base = DESC0;
    @(negedge clk);
    en_set = 1'b0;
    chk(chan_en == 1'b1, "R1 armed", 32'(chan_en), 1);
    g0 = n_gnt; b0 = n_blk; t0 = n_txn; r0 = n_descrd;
    case (trig_sel)
      0: trig_periph = 1'b1;
      1: trig_sw = 1'b1;
      default: trig_evt = 1'b1;
    endcase
    @(negedge clk);
    trig_periph = 1'b0; trig_sw = 1'b0; trig_evt = 1'b0;
    wait_c = 0;
    while (n_txn == t0 && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    chk(n_txn == t0 + 1, {"R8 R9 txn end ", tag}, 32'(n_txn - t0), 1);
    bad = 0;
    for (int a = 32'h800; a < MEM_B; a++) if (mem[a] !== refm[a]) bad++;
    chk(bad == 0, {"R4 R5 dest bytes ", tag}, 32'(bad), 0);
    exp_g = 0;
    exp_bi = 1'b0;
    for (int d = 0; d < nd; d++) begin
      exp_g += (beats_of(d_cnt[d]) + bl - 1) / bl;
      exp_bi |= d_bie[d];
    end
    chk(n_gnt - g0 == exp_g, {"R6 grants ", tag}, 32'(n_gnt - g0), 32'(exp_g));
    chk(n_descrd - r0 == 4 * nd, {"R2 descriptor reads ", tag}, 32'(n_descrd - r0), 32'(4 * nd));
    chk(n_blk - b0 == nd, {"R8 blocks ", tag}, 32'(n_blk - b0), 32'(nd));
    chk(chan_en == 1'b0, {"R9 enable cleared ", tag}, 32'(chan_en), 0);
    chk(blk_irq == exp_bi, {"R10 block flag ", tag}, 32'(blk_irq), 32'(exp_bi));
    chk(txn_irq == d_tie[nd - 1], {"R10 txn flag ", tag}, 32'(txn_irq), 32'(d_tie[nd - 1]));
  endtask

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    rst = 1'b1; en_set = 1'b0; desc_base = '0; burst_len_m1 = '0;
    trig_periph = 1'b0; trig_sw = 1'b0; trig_evt = 1'b0; irq_clr = 1'b0;
    for (int a = 0; a < MEM_B; a++) mem[a] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(chan_en == 1'b0, "R1 reset chan_en", 32'(chan_en), 0);
    chk(mem_req == 1'b0 && arb_req == 1'b0, "R1 reset requests", {30'd0, mem_req, arb_req}, 0);
    chk(blk_irq == 1'b0 && txn_irq == 1'b0, "R1 reset flags", {30'd0, blk_irq, txn_irq}, 0);

    // R1 trigger while disarmed has no effect
    r0 = n_req;
    trig_sw = 1'b1; trig_evt = 1'b1;
    @(negedge clk);
    trig_sw = 1'b0; trig_evt = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_req == r0, "R1 disarmed trigger ignored", 32'(n_req - r0), 0);

    // one block, word beats, both addresses step, burst of 2
    nd = 1;
    d_cnt[0] = 5; d_sz[0] = 2; d_si[0] = 1; d_di[0] = 1; d_bie[0] = 1; d_tie[0] = 1;
    gnt_max = 0;
    run_txn(0, 2, "single");

    // chain of three with mixed sizes and fixed addresses (R5, R8)
    nd = 3;
    d_cnt[0] = 7; d_sz[0] = 1; d_si[0] = 1; d_di[0] = 0; d_bie[0] = 0; d_tie[0] = 0;
    d_cnt[1] = 3; d_sz[1] = 0; d_si[1] = 0; d_di[1] = 1; d_bie[1] = 1; d_tie[1] = 1;
    d_cnt[2] = 4; d_sz[2] = 3; d_si[2] = 1; d_di[2] = 1; d_bie[2] = 0; d_tie[2] = 0;
    gnt_max = 3;
    run_txn(2, 3, "chain");

    // R3 count field zero means 2^CNT_W beats, bursts of 16
    nd = 1;
    d_cnt[0] = 0; d_sz[0] = 0; d_si[0] = 1; d_di[0] = 1; d_bie[0] = 1; d_tie[0] = 1;
    gnt_max = 0;
    run_txn(1, 16, "R3 full count");

    // R10 clear both flags
    chk(blk_irq && txn_irq, "R10 flags set before clear", {30'd0, blk_irq, txn_irq}, 3);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
    chk(!blk_irq && !txn_irq, "R10 flags cleared", {30'd0, blk_irq, txn_irq}, 0);

    // random chains with random grant delays (R7 pause)
    for (int t = 0; t < 12; t++) begin
      nd = $urandom_range(3, 1);
      for (int d = 0; d < nd; d++) begin
        d_cnt[d] = $urandom_range(40, 1);
        d_sz[d]  = $urandom_range(3, 0);
        d_si[d]  = 1'($urandom);
        d_di[d]  = 1'($urandom);
        d_bie[d] = 1'($urandom);
        d_tie[d] = 1'($urandom);
      end
      gnt_max = $urandom_range(6, 0);
      run_txn($urandom_range(2, 0), $urandom_range(16, 1), "random R7");
    end

    chk(v_arb == 0, "R7 no access while arbitrating", 32'(v_arb), 0);
    chk(v_hold == 0, "R11 request held until ack", 32'(v_hold), 0);
    chk(v_data == 0, "R4 write data equals read data", 32'(v_data), 0);
    chk(v_burst == 0, "R6 beats per grant within burst", 32'(v_burst), 0);
    chk(v_pulse == 0, "R9 block pulse one cycle", 32'(v_pulse), 0);
    chk(v_txn == 0, "R9 txn pulse with block pulse", 32'(v_txn), 0);
    report_and_end();
  end
endmodule